// File: doc/BRIEF.md
# Open-Drain Single-Pin I/O Port

This block controls one general-purpose pin from a byte-wide register bus. Three registers, each with a single live bit, hold the output latch, the output-transistor enable and the pull-up enable. The pad is open-drain. A latch value of 0 with the transistor enabled pulls the pin low. A latch value of 1 releases the pin, so the pin is never driven high. Reading the data register returns the pin level as seen through a two-flop synchronizer, not the latch.

Two system conditions override the register settings. In low-power stop mode the output transistor is switched off. The pin then floats unless the pull-up bit is set, in which case the pull-up holds the pin high. While reset is asserted, both the transistor and the pull-up are off and the pin floats. Software places the latch and direction settings first. A power controller then raises the stop input.

Top module: `odpin_port`

## Requirements
- R1: With the direction bit 1, the latch 0, stop low and reset released, pad_oe is 1, so the pin is pulled low.
- R2: With the latch 1, pad_oe is 0 for any direction setting, so the pin is released rather than driven high.
- R3: With the direction bit 0, pad_oe is 0 for any latch value.
- R4: A read at offset 0x12 returns the pin level in bit 0 (0 = low, 1 = high), never the latch. A pin change appears in the read data after the second rising clock edge that follows it.
- R5: While stop_mode is 1, pad_oe is 0 and pad_pu equals the pull-up bit.
- R6: While stop_mode is 0, pad_pu is 0.
- R7: While rst_n is 0, pad_oe and pad_pu are both 0. After reset the direction bit and the pull-up bit read 0. The latch value after reset is not guaranteed.
- R8: The latch is at offset 0x12, the direction bit at 0x13 and the pull-up bit at 0x72, each in bit 0. A write with bus_wr high is taken at the next rising clock edge. The direction and pull-up bits read back at their offsets.
- R9: Bits 7..1 of every register read 0, and writes to those bits have no effect. Any other offset reads 0x00, and a write to it changes no register.
- R10: pad_out is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| stop_mode | input | 1 | Low-power stop flag |
| pad_in | input | 1 | Pin level from the pad receiver |
| pad_oe | output | 1 | Enable for the pull-down output transistor |
| pad_out | output | 1 | Level driven when pad_oe is 1 (always 0) |
| pad_pu | output | 1 | Pull-up enable |

## Verification
Two things can fall in the same clock edge: a register write that would turn on the output transistor, and the entry into stop mode. The bench provokes this by raising stop_mode at the same edge that captures a latch write of 0 while the direction bit is 1. It judges the result by requiring pad_oe to stay 0 and pad_pu to follow the pull-up bit. A second collision is between a pin change and a data read. The bench changes the pin level and reads the data register after one edge and again after two, expecting the old level and then the new one.

// File: rtl/odp_pkg.sv
package odp_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_PULL = 2'd3
   } odp_sel_e;

   // pin states the bench and notes reason about
   typedef enum logic [1:0] {
      PIN_LOW  = 2'd0,
      PIN_HIGH = 2'd1,
      PIN_FLT  = 2'd2
   } odp_pin_e;

endpackage

// File: rtl/odp_sync.sv
module odp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("odp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/odp_regs.sv
module odp_regs
   import odp_pkg::*;
#(
   parameter int              ADDR_W    = 8,
   parameter int              DATA_W    = 8,
   parameter logic [ADDR_W-1:0] OFS_DATA = 'h12,
   parameter logic [ADDR_W-1:0] OFS_DIR  = 'h13,
   parameter logic [ADDR_W-1:0] OFS_PULL = 'h72,
   parameter logic            LATCH_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pin_sync,
   output logic              latch_q,
   output logic              dir_q,
   output logic              pull_q
);
   localparam int PAD_W = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("odp_regs: DATA_W must be at least 2");
      end
      if (OFS_DATA == OFS_DIR || OFS_DATA == OFS_PULL || OFS_DIR == OFS_PULL) begin : g_bad_ofs
         $error("odp_regs: register offsets must differ");
      end
   endgenerate

   odp_sel_e sel;
   logic     bit_rd;
   logic     unused_hi;

   always_comb begin
      if (bus_addr == OFS_DATA)      sel = SEL_DATA;
      else if (bus_addr == OFS_DIR)  sel = SEL_DIR;
      else if (bus_addr == OFS_PULL) sel = SEL_PULL;
      else                           sel = SEL_NONE;
   end

   assign unused_hi = ^bus_wdata[DATA_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= LATCH_RST;
         dir_q   <= 1'b0;
         pull_q  <= 1'b0;
      end else if (bus_wr) begin
         case (sel)
            SEL_DATA: latch_q <= bus_wdata[0];
            SEL_DIR:  dir_q   <= bus_wdata[0];
            SEL_PULL: pull_q  <= bus_wdata[0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_DATA: bit_rd = pin_sync;
         SEL_DIR:  bit_rd = dir_q;
         SEL_PULL: bit_rd = pull_q;
         default:  bit_rd = 1'b0;
      endcase
   end

   assign bus_rdata = {{PAD_W{1'b0}}, bit_rd};
endmodule

// File: rtl/odp_padctl.sv
module odp_padctl (
   input  logic rst_n,
   input  logic stop_mode,
   input  logic latch_q,
   input  logic dir_q,
   input  logic pull_q,
   output logic pad_oe,
   output logic pad_out,
   output logic pad_pu
);
   logic run_ok;

   // reset and stop both silence the transistor; only stop may pull up
   assign run_ok  = rst_n & ~stop_mode;
   assign pad_oe  = run_ok & dir_q & ~latch_q;
   assign pad_out = 1'b0;
   assign pad_pu  = rst_n & stop_mode & pull_q;
endmodule

// File: rtl/odpin_port.sv
module odpin_port #(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] OFS_DATA    = 'h12,
   parameter logic [ADDR_W-1:0] OFS_DIR     = 'h13,
   parameter logic [ADDR_W-1:0] OFS_PULL    = 'h72,
   parameter int                SYNC_STAGES = 2,
   parameter logic              LATCH_RST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              stop_mode,
   input  logic              pad_in,
   output logic              pad_oe,
   output logic              pad_out,
   output logic              pad_pu
);
   logic pin_sync;
   logic latch_q;
   logic dir_q;
   logic pull_q;

   odp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pad_in),
      .q_out (pin_sync)
   );

   odp_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .OFS_DATA  (OFS_DATA),
      .OFS_DIR   (OFS_DIR),
      .OFS_PULL  (OFS_PULL),
      .LATCH_RST (LATCH_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_sync  (pin_sync),
      .latch_q   (latch_q),
      .dir_q     (dir_q),
      .pull_q    (pull_q)
   );

   odp_padctl u_pad (
      .rst_n     (rst_n),
      .stop_mode (stop_mode),
      .latch_q   (latch_q),
      .dir_q     (dir_q),
      .pull_q    (pull_q),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out),
      .pad_pu    (pad_pu)
   );
endmodule

// File: rtl/odpin_port_chk.sv
module odpin_port_chk #(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] OFS_DATA = 'h12,
   parameter logic [ADDR_W-1:0] OFS_DIR  = 'h13,
   parameter logic [ADDR_W-1:0] OFS_PULL = 'h72
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              stop_mode,
   input logic              pad_in,
   input logic              pad_oe,
   input logic              pad_pu
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R7
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!pad_oe && !pad_pu));

   // R5
   stop_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_mode |-> !pad_oe);

   // R6
   run_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_mode |-> !pad_pu);

   // R9
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:1] == '0);

   // R8
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0 && $past(bus_wr) && $past(bus_addr) == OFS_DIR && bus_addr == OFS_DIR)
      |-> bus_rdata[0] == $past(bus_wdata[0]));

   // R8
   pull_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0 && $past(bus_wr) && $past(bus_addr) == OFS_PULL && bus_addr == OFS_PULL)
      |-> bus_rdata[0] == $past(bus_wdata[0]));

   // R4
   pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && bus_addr == OFS_DATA) |-> bus_rdata[0] == $past(pad_in, 2));
endmodule

bind odpin_port odpin_port_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .OFS_DATA (OFS_DATA),
   .OFS_DIR  (OFS_DIR),
   .OFS_PULL (OFS_PULL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .stop_mode (stop_mode),
   .pad_in    (pad_in),
   .pad_oe    (pad_oe),
   .pad_pu    (pad_pu)
);

// File: tb/odpin_port_test.sv
`timescale 1ns/1ps
module odpin_port_test;
   localparam logic [7:0] A_DATA = 8'h12;
   localparam logic [7:0] A_DIR  = 8'h13;
   localparam logic [7:0] A_PULL = 8'h72;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       stop_mode = 1'b0;
   logic       pad_in;
   logic       pad_oe, pad_out, pad_pu;
   logic       ext_en = 1'b0, ext_val = 1'b0, float_val = 1'b0;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   // pin resolution: outside driver, then the pull-down, then the pull-up, else floating
   assign pad_in = ext_en ? ext_val : (pad_oe ? 1'b0 : (pad_pu ? 1'b1 : float_val));

   odpin_port uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_mode(stop_mode),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   function automatic logic exp_oe(logic rn, logic stp, logic dir, logic lat);
      return rn && !stp && dir && !lat;
   endfunction

   function automatic logic exp_pu(logic rn, logic stp, logic pu);
      return rn && stp && pu;
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] r;
      void'($urandom(32'd1234));
      tick(2);
      // R7 outputs quiet in reset
      check("R7 oe in reset", {7'd0, pad_oe}, 8'h00);
      check("R7 pu in reset", {7'd0, pad_pu}, 8'h00);
      rst_n = 1'b1;
      tick();
      rd(A_DIR, r);  check("R7 dir after reset", r, 8'h00);
      rd(A_PULL, r); check("R7 pull after reset", r, 8'h00);
      check("R10 pad_out", {7'd0, pad_out}, 8'h00);

      // R1 drive low
      wr(A_DATA, 8'h00); wr(A_DIR, 8'h01);
      check("R1 oe drive low", {7'd0, pad_oe}, 8'h01);
      // R2 latch 1 releases
      wr(A_DATA, 8'h01);
      check("R2 latch 1 release", {7'd0, pad_oe}, 8'h00);
      // R4 read pin not latch: latch 1, outside drives low
      ext_en = 1'b1; ext_val = 1'b0;
      tick(3);
      rd(A_DATA, r); check("R4 pin not latch", r, 8'h00);
      // R4 latency: change pin, old after one edge, new after two
      tick();
      ext_val = 1'b1;
      tick(); rd(A_DATA, r); check("R4 one edge old", r, 8'h00);
      tick(); rd(A_DATA, r); check("R4 two edges new", r, 8'h01);
      ext_en = 1'b0;
      // R3 direction 0 with latch 0
      wr(A_DIR, 8'h00); wr(A_DATA, 8'h00);
      check("R3 input mode", {7'd0, pad_oe}, 8'h00);

      // R9 upper bits ignored, unmapped offsets
      wr(A_PULL, 8'hFE);
      rd(A_PULL, r); check("R9 upper bits ignored", r, 8'h00);
      wr(A_PULL, 8'hFF);
      rd(A_PULL, r); check("R9 upper bits read 0", r, 8'h01);
      wr(8'h14, 8'hFF);
      rd(A_DIR, r); check("R9 unmapped write", r, 8'h00);
      rd(8'h14, r); check("R9 unmapped read", r, 8'h00);

      // collision: stop rises at the edge that captures latch 0 with dir 1
      wr(A_DATA, 8'h01); wr(A_DIR, 8'h01);
      bus_addr = A_DATA; bus_wdata = 8'h00; bus_wr = 1'b1; stop_mode = 1'b1;
      tick(); bus_wr = 1'b0;
      check("R5 stop wins over write oe", {7'd0, pad_oe}, 8'h00);
      check("R5 stop pull-up on", {7'd0, pad_pu}, 8'h01);
      tick(3);
      rd(A_DATA, r); check("R5 pin held high", r, 8'h01);
      stop_mode = 1'b0;
      #1;
      check("R6 pull off after stop", {7'd0, pad_pu}, 8'h00);
      check("R1 drive after stop", {7'd0, pad_oe}, 8'h01);
      // R7 reset in stop with pull-up set
      stop_mode = 1'b1;
      tick();
      rst_n = 1'b0;
      #1;
      check("R7 reset kills pull-up", {7'd0, pad_pu}, 8'h00);
      check("R7 reset kills oe", {7'd0, pad_oe}, 8'h00);
      tick(2);
      rst_n = 1'b1; stop_mode = 1'b0;
      tick();

      // random mix
      for (int it = 0; it < 300; it++) begin
         logic d, l, p, s, eo, ep;
         logic exp_pin;
         d = 1'($urandom); l = 1'($urandom); p = 1'($urandom); s = 1'($urandom);
         stop_mode = 1'b0;
         wr(A_DATA, {7'($urandom), l});
         wr(A_DIR,  {7'($urandom), d});
         wr(A_PULL, {7'($urandom), p});
         stop_mode = s;
         float_val = 1'($urandom);
         eo = exp_oe(1'b1, s, d, l);
         ep = exp_pu(1'b1, s, p);
         ext_en = eo ? 1'b0 : 1'($urandom);
         ext_val = 1'($urandom);
         #1;
         check("R1/R2/R3/R5 rand oe", {7'd0, pad_oe}, {7'd0, eo});
         check("R5/R6 rand pu", {7'd0, pad_pu}, {7'd0, ep});
         check("R10 rand pad_out", {7'd0, pad_out}, 8'h00);
         tick(3);
         exp_pin = ext_en ? ext_val : (eo ? 1'b0 : (ep ? 1'b1 : float_val));
         rd(A_DATA, r); check("R4 rand pin read", r, {7'd0, exp_pin});
         rd(A_DIR, r);  check("R8 rand dir read", r, {7'd0, d});
         rd(A_PULL, r); check("R8 rand pull read", r, {7'd0, p});
         tick();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule